// File: doc/BRIEF.md
# Programmable Asynchronous SRAM Bus Sequencer

This block turns single-word read and write requests from an internal host into asynchronous cycles on an external parallel memory bus of the kind used by SRAM, pseudo-static RAM and asynchronous NOR flash. A cycle has up to four phases: address setup, data setup (the strobe phase), address hold, and a turnaround gap. Each phase lasts a number of system-clock cycles taken from a programmable timing field. There is one timing set for reads. A second set can be selected for writes.

The host raises `req` for one cycle with the direction, address and write data. The block latches the request and the timing set it needs, then runs the bus sequence. It pulses `ready` for one cycle when the whole sequence has finished. The external data lane can be 8 or 16 bits wide. The low address bits can optionally be sent over the data lines during the address phase, so that address and data share one set of wires. A bank enable and a write-permission bit can suppress the bus activity. In that case the request completes at once.

Top module: `asram_seq`

## Requirements
- R1: During and right after reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `ready` is 0.
- R2: Counting the first cycle after the accepting edge as cycle 0, the address setup phase occupies cycles 0 to S-1, where S is the setup field (0..15). In this phase `mem_cs_n` is 0, both other strobes are 1, and `mem_addr` holds the request address.
- R3: The data setup phase follows and lasts D cycles, where D is the data field (1..255; a field value of 0 acts as 1). In it `mem_cs_n` is 0, and `mem_oe_n` is 0 for a read or `mem_we_n` is 0 for a write. The two strobes are never both 0.
- R4: After the data phase, the address hold phase lasts H cycles (0..15). All strobes are 1 and `mem_addr` is unchanged.
- R5: When `cfg_mux_en`=1, a turnaround gap of T cycles (0..15) follows the hold phase. All strobes are 1 in the gap. When `cfg_mux_en`=0 the field T adds no cycles.
- R6: When `cfg_mux_en`=1, the low address bits are driven on `mem_dq_o` with `mem_dq_oe`=1 during the address setup phase.
- R7: When `cfg_wide`=0 the lane is 8 bits wide. `mem_dq_o[15:8]` is 0 whenever it is driven, and `rdata[15:8]` is 0 after a read. When `cfg_wide`=1 all 16 bits are used.
- R8: A write uses the `tw_*` fields when `cfg_ext_en`=1 and the `tr_*` fields when `cfg_ext_en`=0. A read always uses `tr_*`.
- R9: A write request while `cfg_wr_en`=0 produces no strobe and `mem_dq_oe` stays 0. `ready` is 1 in cycle 0.
- R10: Any request while `cfg_bank_en`=0 produces no strobe and `mem_dq_oe` stays 0. `ready` is 1 in cycle 0.
- R11: `mem_dq_oe` is 1 only during the data phase of a write, or during the address phase when multiplexing is on. It is never 1 while `mem_oe_n` is 0.
- R12: `rdata` takes the value of `mem_dq_i` in the last cycle of the read data phase. It holds that value while `ready` is 1.
- R13: `ready` is 1 for exactly one cycle, in cycle S+D+H+T (T counted only when multiplexing is on). The timing fields, mode bits and address are latched at acceptance, so changes made later do not affect the cycle under way.
- R14: `req` is ignored while a sequence is in progress. A held or repeated request neither alters `mem_addr` nor restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host request, sampled only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DQ_W | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | DQ_W | Captured read data |
| cfg_bank_en | input | 1 | Bank enable |
| cfg_wr_en | input | 1 | Write permission |
| cfg_ext_en | input | 1 | Separate write timing set |
| cfg_mux_en | input | 1 | Address on data lines during setup |
| cfg_wide | input | 1 | 1 = 16-bit lane, 0 = 8-bit lane |
| tr_setup | input | TA_W | Read/common address setup cycles |
| tr_hold | input | TA_W | Read/common address hold cycles |
| tr_dlen | input | TD_W | Read/common data phase cycles |
| tr_turn | input | TA_W | Read/common turnaround cycles |
| tw_setup | input | TA_W | Write address setup cycles |
| tw_hold | input | TA_W | Write address hold cycles |
| tw_dlen | input | TD_W | Write data phase cycles |
| tw_turn | input | TA_W | Write turnaround cycles |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Address bus |
| mem_dq_o | output | DQ_W | Data lines, outgoing value |
| mem_dq_oe | output | 1 | Data line drive enable |
| mem_dq_i | input | DQ_W | Data lines, incoming value |

## Verification
The bench builds the block with its defaults: a 20-bit address, a 16-bit lane, 4-bit setup, hold and turnaround fields and an 8-bit data field. It sweeps setup over {0,1,3}, data over {0,1,4}, hold and turnaround over {0,2}, and crosses these with every combination of multiplexing, lane width, separate write timing and direction. The write set is always kept distinct from the read set. Because the fields are so short, every phase order is reached, including the ones where a zero-length phase is skipped, and the bench can compare each bus cycle against a phase count it works out itself. A memory model that changes its read data on every strobe cycle exposes any capture made in the wrong cycle. Directed cases cover blocked writes, a disabled bank, and configuration and request changes made during a sequence.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int TA_W = 4;   // setup, hold and turnaround field width
    localparam int TD_W = 8;   // data phase field width

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ASET  = 3'd1,
        PH_DSET  = 3'd2,
        PH_AHOLD = 3'd3,
        PH_TURN  = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;

    typedef struct packed {
        logic [TA_W-1:0] setup;
        logic [TA_W-1:0] hold;
        logic [TD_W-1:0] dlen;
        logic [TA_W-1:0] turn;
    } tset_t;

endpackage

// File: rtl/asram_tsel.sv
module asram_tsel
    import asram_pkg::*;
(
    input  tset_t rd_set,
    input  tset_t wr_set,
    input  logic  is_write,
    input  logic  ext_en,
    output tset_t chosen
);

    always_comb begin
        chosen = (is_write && ext_en) ? wr_set : rd_set;
    end

endmodule

// File: rtl/asram_mask.sv
module asram_mask #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic         wide,
    output logic [W-1:0] y
);

    localparam int HALF = W / 2;

    for (genvar i = 0; i < W; i++) begin : g_lane
        if (i < HALF) begin : g_low
            assign y[i] = x[i];
        end else begin : g_high
            assign y[i] = x[i] & wide;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DQ_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic              cfg_bank_en,
    input  logic              cfg_wr_en,
    input  logic              cfg_mux_en,
    input  logic              cfg_wide,
    input  tset_t             sel_set,
    input  logic [DQ_W-1:0]   rd_in,
    output phase_e            phase,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DQ_W-1:0]   wdata_q,
    output logic              we_q,
    output logic              mux_q,
    output logic              wide_q,
    output logic [DQ_W-1:0]   rdata,
    output logic              ready
);

    typedef struct packed {
        phase_e            ph;
        logic [TD_W-1:0]   cnt;
        tset_t             tim;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   wdata;
        logic              we;
        logic              mux;
        logic              wide;
        logic [DQ_W-1:0]   rdata;
    } st_t;

    st_t s_d, s_q;

    function automatic logic [TD_W-1:0] len_of(phase_e p, tset_t t);
        case (p)
            PH_ASET:  len_of = TD_W'(t.setup);
            PH_DSET:  len_of = (t.dlen == '0) ? TD_W'(1) : t.dlen;
            PH_AHOLD: len_of = TD_W'(t.hold);
            PH_TURN:  len_of = TD_W'(t.turn);
            default:  len_of = TD_W'(1);
        endcase
    endfunction

    // successor phase, skipping phases of zero length
    function automatic phase_e succ(phase_e p, tset_t t, logic mux);
        logic turn_on;
        turn_on = mux && (t.turn != '0);
        case (p)
            PH_IDLE:  succ = (t.setup != '0) ? PH_ASET : PH_DSET;
            PH_ASET:  succ = PH_DSET;
            PH_DSET:  succ = (t.hold != '0) ? PH_AHOLD : (turn_on ? PH_TURN : PH_DONE);
            PH_AHOLD: succ = turn_on ? PH_TURN : PH_DONE;
            PH_TURN:  succ = PH_DONE;
            default:  succ = PH_IDLE;
        endcase
    endfunction

    always_comb begin
        phase_e nx;
        s_d = s_q;
        nx  = PH_IDLE;
        case (s_q.ph)
            PH_IDLE: begin
                if (req) begin
                    s_d.tim   = sel_set;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    s_d.we    = req_we;
                    s_d.mux   = cfg_mux_en;
                    s_d.wide  = cfg_wide;
                    if (!cfg_bank_en || (req_we && !cfg_wr_en)) begin
                        s_d.ph  = PH_DONE;
                        s_d.cnt = '0;
                    end else begin
                        nx      = succ(PH_IDLE, sel_set, cfg_mux_en);
                        s_d.ph  = nx;
                        s_d.cnt = len_of(nx, sel_set) - TD_W'(1);
                    end
                end
            end
            PH_DONE: begin
                s_d.ph = PH_IDLE;
            end
            default: begin
                if (s_q.cnt == '0) begin
                    if (s_q.ph == PH_DSET && !s_q.we) begin
                        s_d.rdata = rd_in;
                    end
                    nx      = succ(s_q.ph, s_q.tim, s_q.mux);
                    s_d.ph  = nx;
                    s_d.cnt = len_of(nx, s_q.tim) - TD_W'(1);
                end else begin
                    s_d.cnt = s_q.cnt - TD_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase   = s_q.ph;
    assign addr_q  = s_q.addr;
    assign wdata_q = s_q.wdata;
    assign we_q    = s_q.we;
    assign mux_q   = s_q.mux;
    assign wide_q  = s_q.wide;
    assign rdata   = s_q.rdata;
    assign ready   = (s_q.ph == PH_DONE);

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R13
    AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_IDLE && req && req_we && !cfg_wr_en) |=> ready); // R9
    AST_BANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_IDLE && req && !cfg_bank_en) |=> ready); // R10
    AST_BUSY_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_IDLE) |=> $stable(addr_q)); // R14

endmodule

// File: rtl/asram_pins.sv
module asram_pins
    import asram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DQ_W   = 16
) (
    input  phase_e            phase,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DQ_W-1:0]   wdata_q,
    input  logic              we_q,
    input  logic              mux_q,
    input  logic              wide_q,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DQ_W-1:0]   dq_o,
    output logic              dq_oe
);

    logic            drive_addr;
    logic            drive_data;
    logic [DQ_W-1:0] raw;

    always_comb begin
        drive_addr = (phase == PH_ASET) && mux_q;
        drive_data = (phase == PH_DSET) && we_q;
        cs_n       = !((phase == PH_ASET) || (phase == PH_DSET));
        oe_n       = !((phase == PH_DSET) && !we_q);
        we_n       = !drive_data;
        dq_oe      = drive_addr || drive_data;
        addr       = addr_q;
        if (drive_data) begin
            raw = wdata_q;
        end else if (drive_addr) begin
            raw = addr_q[DQ_W-1:0];
        end else begin
            raw = '0;
        end
    end

    asram_mask #(.W(DQ_W)) u_out_mask (
        .x    (raw),
        .wide (wide_q),
        .y    (dq_o)
    );

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DQ_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              ready,
    output logic [DQ_W-1:0]   rdata,
    input  logic              cfg_bank_en,
    input  logic              cfg_wr_en,
    input  logic              cfg_ext_en,
    input  logic              cfg_mux_en,
    input  logic              cfg_wide,
    input  logic [TA_W-1:0]   tr_setup,
    input  logic [TA_W-1:0]   tr_hold,
    input  logic [TD_W-1:0]   tr_dlen,
    input  logic [TA_W-1:0]   tr_turn,
    input  logic [TA_W-1:0]   tw_setup,
    input  logic [TA_W-1:0]   tw_hold,
    input  logic [TD_W-1:0]   tw_dlen,
    input  logic [TA_W-1:0]   tw_turn,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DQ_W-1:0]   mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DQ_W-1:0]   mem_dq_i
);

    tset_t             rd_set, wr_set, sel_set;
    phase_e            phase;
    logic [ADDR_W-1:0] addr_q;
    logic [DQ_W-1:0]   wdata_q;
    logic [DQ_W-1:0]   rd_in;
    logic              we_q, mux_q, wide_q;

    assign rd_set = '{setup: tr_setup, hold: tr_hold, dlen: tr_dlen, turn: tr_turn};
    assign wr_set = '{setup: tw_setup, hold: tw_hold, dlen: tw_dlen, turn: tw_turn};

    asram_tsel u_tsel (
        .rd_set   (rd_set),
        .wr_set   (wr_set),
        .is_write (req_we),
        .ext_en   (cfg_ext_en),
        .chosen   (sel_set)
    );

    asram_mask #(.W(DQ_W)) u_in_mask (
        .x    (mem_dq_i),
        .wide (wide_q),
        .y    (rd_in)
    );

    asram_ctrl #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .cfg_bank_en (cfg_bank_en),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_mux_en  (cfg_mux_en),
        .cfg_wide    (cfg_wide),
        .sel_set     (sel_set),
        .rd_in       (rd_in),
        .phase       (phase),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .we_q        (we_q),
        .mux_q       (mux_q),
        .wide_q      (wide_q),
        .rdata       (rdata),
        .ready       (ready)
    );

    asram_pins #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_pins (
        .phase   (phase),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .we_q    (we_q),
        .mux_q   (mux_q),
        .wide_q  (wide_q),
        .cs_n    (mem_cs_n),
        .oe_n    (mem_oe_n),
        .we_n    (mem_we_n),
        .addr    (mem_addr),
        .dq_o    (mem_dq_o),
        .dq_oe   (mem_dq_oe)
    );

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n); // R3
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R3
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe); // R11
    AST_ADDR_STABLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R2

endmodule

// File: tb/asram_seq_bench.sv
module asram_seq_bench;
    import asram_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic req = 0, req_we = 0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic ready;
    logic [15:0] rdata;
    logic cfg_bank_en = 1, cfg_wr_en = 1, cfg_ext_en = 0, cfg_mux_en = 0, cfg_wide = 1;
    logic [3:0] tr_setup = 0, tr_hold = 0, tr_turn = 0, tw_setup = 0, tw_hold = 0, tw_turn = 0;
    logic [7:0] tr_dlen = 1, tw_dlen = 1;
    logic mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [19:0] mem_addr;
    logic [15:0] mem_dq_o, mem_dq_i;
    logic [7:0] oe_cnt;

    int n_cmp = 0, n_bad = 0, cyc = 0, idx = 0;

    asram_seq u_asram_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .rdata(rdata),
        .cfg_bank_en(cfg_bank_en), .cfg_wr_en(cfg_wr_en), .cfg_ext_en(cfg_ext_en),
        .cfg_mux_en(cfg_mux_en), .cfg_wide(cfg_wide),
        .tr_setup(tr_setup), .tr_hold(tr_hold), .tr_dlen(tr_dlen), .tr_turn(tr_turn),
        .tw_setup(tw_setup), .tw_hold(tw_hold), .tw_dlen(tw_dlen), .tw_turn(tw_turn),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    function automatic logic [15:0] pat(logic [19:0] a);
        return 16'(a[15:0] * 16'd40503 + 16'h1357);
    endfunction

    function automatic logic [15:0] msk(logic [15:0] x, logic w);
        return w ? x : {8'h00, x[7:0]};
    endfunction

    // memory model: read data changes on every strobe cycle
    always_ff @(posedge clk) oe_cnt <= mem_oe_n ? 8'd0 : oe_cnt + 8'd1;
    assign mem_dq_i = mem_oe_n ? 16'h0000 : (pat(mem_addr) ^ {8'h00, oe_cnt});

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pins();
        return {23'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, ready, mem_dq_o, mem_addr};
    endfunction

    // one request; perturb holds req with another address and alters the config mid-run
    task automatic txn(logic we, logic [19:0] a, logic [15:0] wd, bit perturb);
        int s, d, h, t, total, k;
        bit blocked, ext_set;
        logic mux, wide;
        logic [15:0] edq;
        logic ecs, eoe, ewe, eoen, erdy;
        string tag;
        ext_set = we && cfg_ext_en;
        s = ext_set ? int'(tw_setup) : int'(tr_setup);
        d = ext_set ? int'(tw_dlen) : int'(tr_dlen);
        if (d == 0) d = 1;
        h = ext_set ? int'(tw_hold) : int'(tr_hold);
        t = ext_set ? int'(tw_turn) : int'(tr_turn);
        mux = cfg_mux_en; wide = cfg_wide;
        if (!mux) t = 0;
        blocked = !cfg_bank_en || (we && !cfg_wr_en);
        total = blocked ? 0 : s + d + h + t;
        @(negedge clk);
        req = 1; req_we = we; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req = 0;
        for (int n = 0; n <= total; n++) begin
            if (perturb && n == 0) begin
                req = 1; req_addr = ~a; tr_dlen = 8'd200; tr_setup = 4'd15; tw_dlen = 8'd200;
            end
            ecs = 1; eoe = 1; ewe = 1; eoen = 0; erdy = 0; edq = 16'h0;
            if (blocked) begin
                erdy = 1;
                tag = cfg_bank_en ? "R9" : "R10";
            end else if (n < s) begin
                ecs = 0;
                if (mux) begin eoen = 1; edq = msk(a[15:0], wide); end
                tag = mux ? "R2 R6 R11" : "R2";
            end else if (n < s + d) begin
                ecs = 0;
                if (we) begin ewe = 0; eoen = 1; edq = msk(wd, wide); end
                else eoe = 0;
                tag = we ? "R3 R8 R11" : "R3 R11";
            end else if (n < s + d + h) begin
                tag = "R4";
            end else if (n < total) begin
                tag = "R5";
            end else begin
                erdy = 1;
                tag = "R13 R5";
            end
            if (!wide) tag = {tag, " R7"};
            if (perturb) tag = {tag, " R13 R14"};
            chk(tag, pins(), {23'd0, ecs, eoe, ewe, eoen, erdy, edq, a});
            if (n == total && !we && !blocked) begin
                k = d - 1;
                chk(wide ? "R12" : "R12 R7", {48'd0, rdata},
                    {48'd0, msk(pat(a) ^ 16'(k), wide)});
            end
            if (perturb && n == total) req = 0;
            @(negedge clk);
        end
        chk("R13 R14", {63'd0, ready}, 64'd0);
    endtask

    initial begin : main
        int sv[3], dv[3];
        sv = '{0, 1, 3};
        dv = '{0, 1, 4};
        repeat (3) @(negedge clk);
        chk("R1", pins() & 64'h0000_01F0_0000_0000 | {23'd0, 5'b0, 36'd0},
            {23'd0, 5'b11100, 36'd0});
        rst_n = 1;
        @(negedge clk);
        chk("R1", {59'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, ready}, {59'd0, 5'b11100});
        for (int ie = 0; ie < 2; ie++)
        for (int im = 0; im < 2; im++)
        for (int iw = 0; iw < 2; iw++)
        for (int idir = 0; idir < 2; idir++)
        for (int is = 0; is < 3; is++)
        for (int id = 0; id < 3; id++)
        for (int ih = 0; ih < 2; ih++)
        for (int it = 0; it < 2; it++) begin
            cfg_ext_en = ie[0]; cfg_mux_en = im[0]; cfg_wide = iw[0];
            tr_setup = 4'(sv[is]); tr_dlen = 8'(dv[id]); tr_hold = 4'(ih * 2); tr_turn = 4'(it * 2);
            tw_setup = 4'(sv[is] + 2); tw_dlen = 8'(dv[id] + 3);
            tw_hold = 4'(ih * 2 + 1); tw_turn = 4'(it * 2 + 1);
            idx++;
            txn(idir[0], 20'(idx * 4099 + 17), 16'(idx * 7919 + 16'hBEEF), 1'b0);
        end
        // R9: write blocked; R10: bank disabled
        cfg_ext_en = 0; cfg_mux_en = 1; cfg_wide = 1;
        tr_setup = 2; tr_dlen = 3; tr_hold = 1; tr_turn = 1;
        cfg_wr_en = 0;
        txn(1'b1, 20'h12345, 16'hA5A5, 1'b0);
        txn(1'b0, 20'h00321, 16'h0000, 1'b0);   // reads still run (R9 scope)
        cfg_wr_en = 1; cfg_bank_en = 0;
        txn(1'b0, 20'h54321, 16'h0000, 1'b0);
        txn(1'b1, 20'h0ABCD, 16'h1111, 1'b0);
        cfg_bank_en = 1;
        // R13/R14: config and request change during the run
        tr_setup = 2; tr_dlen = 3; tr_hold = 1; tr_turn = 1;
        txn(1'b0, 20'h0F00D, 16'h0000, 1'b1);
        tr_setup = 1; tr_dlen = 2; tr_hold = 0; tr_turn = 0;
        tw_setup = 1; tw_dlen = 2; tw_hold = 0; tw_turn = 0;
        cfg_ext_en = 1;
        txn(1'b1, 20'h0BEEF, 16'h4242, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        wait (cyc > 190000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule